// File: doc/BRIEF.md
# Nonvolatile Byte Store Programming Controller

This block sits between a host register bus and a 128-byte nonvolatile data store, modelled here as an internal byte array. The host reaches three registers through a 2-bit select: a location pointer, a data byte and a command/status byte. A read copies the selected byte into the data register. A programming operation can take one of three forms. The first erases and then stores in a single pass. The second only erases, setting the byte to all ones. The third only writes, which can clear bits but never set them. Splitting erase and write lets software save time when the old contents are already known.

Programming is guarded by a two-step unlock. The host first sets an arming bit, which stays open for a short window. A start request is honoured only inside that window. Each operation lasts a mode-dependent number of clock cycles, derived from the required millisecond times and the clock frequency parameter. While the store is idle, a level interrupt can be raised for software that waits on completion.

Top module: `nvm_prog_ctrl`

## Requirements
- R1: Select 0 is the location pointer: a 7-bit field that reads with bit 7 as zero. Select 1 is the data byte, which the host can write and read back. Select 3 always reads zero.
- R2: After a synchronous reset with no operation in progress, the pointer, the data byte and the command byte all read zero and the interrupt output is low.
- R3: The command byte at select 2 has this layout: bits 7:6 always read zero, bits 5:4 hold the mode, bit 3 is the ready-interrupt enable, bit 2 is the arming bit, bit 1 is the start/busy bit and bit 0 is the read request, which always reads zero.
- R4: Writing 1 to bit 2 arms the controller. Bit 2 then reads 1 for exactly 4 cycles and clears by itself. Writing 0 to it has no effect.
- R5: A write with bit 1 set starts an operation only if the arming bit is open on that clock edge. This means the 1st to 4th edge after the arming write, and never the same write. A start request outside the window leaves the busy bit at 0 and the store unchanged.
- R6: Bit 1 reads 1 for exactly ATOMIC cycles for mode 00, where ATOMIC = CLK_HZ*34/10000. For every other mode it reads 1 for SPLIT cycles, where SPLIT = CLK_HZ*18/10000. It clears itself when the operation ends.
- R7: Mode 00 (erase then write) leaves the target byte equal to the data byte.
- R8: Mode 01 (erase only) leaves the target byte at 8'hFF.
- R9: Mode 10 (write only) leaves the target byte equal to the old byte ANDed with the data byte.
- R10: Mode 11 leaves the store unchanged.
- R11: While an operation is in progress, writes to the mode field are ignored. The operation still uses the pointer, data and mode captured when it started.
- R12: A reset during an operation keeps the mode field and lets the operation finish. A reset while idle clears the mode field to 00.
- R13: A read request (bit 0) while idle loads the data byte from the store one cycle after the request. A read request while busy is ignored.
- R14: The interrupt output is high exactly when the ready-interrupt enable is set, the global enable input is high and no operation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 2 | Register select: 0 pointer, 1 data, 2 command, 3 unused |
| host_we | input | 1 | Write strobe for the selected register |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data of the selected register (combinational) |
| glob_ie | input | 1 | Global interrupt enable |
| rdy_irq | output | 1 | Level ready interrupt |

## Verification
The assertions assume the host writes at most one register per cycle. They also assume the operation timer starts idle at power-up, since the timer is deliberately left out of reset. The stimulus drives every bus change on the falling clock edge and holds the write strobe for exactly one rising edge. It programs the store only after an arming write, and it avoids issuing a read request on the very edge an operation ends. Reset is applied only as a whole number of cycles with the write strobe low.

// File: rtl/nvm_prog_pkg.sv
// Shared definitions for the nonvolatile byte store programming controller.
// Assumes an 8-bit host data path; the command byte layout is fixed because
// host software decodes it bit by bit.
package nvm_prog_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        MODE_ATOMIC = 2'b00,
        MODE_ERASE  = 2'b01,
        MODE_WRITE  = 2'b10,
        MODE_RSVD   = 2'b11
    } nvm_mode_e;

    typedef enum logic [1:0] {
        SEL_PTR  = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CMD  = 2'd2,
        SEL_NONE = 2'd3
    } nvm_sel_e;

    // Command byte bit positions
    localparam int CMD_RE_BIT   = 0;
    localparam int CMD_PE_BIT   = 1;
    localparam int CMD_ARM_BIT  = 2;
    localparam int CMD_IE_BIT   = 3;
    localparam int CMD_MODE_LSB = 4;

    localparam logic [DATA_W-1:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/nvm_arm_window.sv
// Arming window for the programming unlock sequence.
// A pulse on arm opens the window for ARM_CYC cycles; re-arming restarts it.
// Assumes arm is a single-cycle strobe from the register decode.
module nvm_arm_window #(
    parameter int ARM_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic open
);
    localparam int CW = $clog2(ARM_CYC + 1);

    logic [CW-1:0] left_q;

    // Load the window length on arm, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (arm) begin
            left_q <= CW'(ARM_CYC);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign open = (left_q != '0);

    assert_arm_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> open);

    assert_window_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm && !open) |=> !open);

endmodule

// File: rtl/nvm_op_timer.sv
// Programming duration timer. Loads a mode-dependent cycle count on start
// and reports busy until it runs out; done marks the final busy cycle.
// Not cleared by reset so an operation in flight survives a reset; the
// counter is assumed idle at power-up.
module nvm_op_timer
    import nvm_prog_pkg::*;
#(
    parameter int ATOMIC_CYC = 170000,
    parameter int SPLIT_CYC  = 90000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  nvm_mode_e mode,
    output logic      busy,
    output logic      done
);
    localparam int MAXC = (ATOMIC_CYC > SPLIT_CYC) ? ATOMIC_CYC : SPLIT_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt_q;

    // Load the operation length on start, then count down once per cycle.
    always_ff @(posedge clk) begin
        if (start) begin
            cnt_q <= (mode == MODE_ATOMIC) ? CW'(ATOMIC_CYC) : CW'(SPLIT_CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));

    assert_start_sets_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    assert_no_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    assert_busy_ends_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

endmodule

// File: rtl/nvm_cell_array.sv
// Byte store model. Captures the target, data and mode when an operation
// starts and applies the result when the timer signals done. The contents
// are never reset because the store is nonvolatile.
// Assumes start and done never fall on the same edge.
module nvm_cell_array
    import nvm_prog_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  nvm_mode_e         mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              done,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    nvm_mode_e         op_mode_q;
    logic [ADDR_W-1:0] op_addr_q;
    logic [DATA_W-1:0] op_data_q;
    logic [DATA_W-1:0] tgt_byte;

    // Capture the operation parameters at start.
    always_ff @(posedge clk) begin
        if (start) begin
            op_mode_q <= mode;
            op_addr_q <= addr;
            op_data_q <= wdata;
        end
    end

    // Apply the programming result to the target byte at completion.
    always_ff @(posedge clk) begin
        if (done) begin
            case (op_mode_q)
                MODE_ATOMIC: mem[op_addr_q] <= op_data_q;
                MODE_ERASE:  mem[op_addr_q] <= ERASED_BYTE;
                MODE_WRITE:  mem[op_addr_q] <= mem[op_addr_q] & op_data_q;
                default:     ;
            endcase
        end
    end

    assign rd_data  = mem[rd_addr];
    assign tgt_byte = mem[op_addr_q];

    assert_rsvd_no_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_mode_q == MODE_RSVD) |=> $stable(tgt_byte));

    assert_write_only_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_mode_q == MODE_WRITE) |=> ((tgt_byte & ~$past(tgt_byte)) == '0));

endmodule

// File: rtl/nvm_prog_ctrl.sv
// Register front end of the nonvolatile byte store programming controller.
// Decodes host writes to the pointer, data and command registers, runs
// the arm-then-start unlock, and drives the level ready interrupt.
// Assumes one host access per cycle and a combinational read port.
module nvm_prog_ctrl
    import nvm_prog_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int CLK_HZ  = 50_000_000,
    parameter int ARM_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] host_sel,
    input  logic       host_we,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       glob_ie,
    output logic       rdy_irq
);
    localparam longint ATOMIC_L   = longint'(CLK_HZ) * 34 / 10000;
    localparam longint SPLIT_L    = longint'(CLK_HZ) * 18 / 10000;
    localparam int     ATOMIC_CYC = int'(ATOMIC_L);
    localparam int     SPLIT_CYC  = int'(SPLIT_L);

    logic [ADDR_W-1:0] ptr_q;
    logic [DATA_W-1:0] data_q;
    nvm_mode_e         mode_q;
    logic              ie_q;
    logic              rd_pend_q;

    logic wr_ptr, wr_data, wr_cmd;
    logic arm, arm_open, start, rd_req;
    logic busy, done;
    logic [DATA_W-1:0] store_byte;
    nvm_mode_e         new_mode;
    logic [1:0]        unused_hi;

    assign unused_hi = host_wdata[7:6];

    assign wr_ptr  = host_we && (host_sel == SEL_PTR);
    assign wr_data = host_we && (host_sel == SEL_DATA);
    assign wr_cmd  = host_we && (host_sel == SEL_CMD);

    assign new_mode = nvm_mode_e'(host_wdata[CMD_MODE_LSB +: 2]);
    assign arm      = wr_cmd && host_wdata[CMD_ARM_BIT];
    assign start    = rst_n && wr_cmd && host_wdata[CMD_PE_BIT] && arm_open && !busy;
    assign rd_req   = wr_cmd && host_wdata[CMD_RE_BIT] && !busy;

    nvm_arm_window #(.ARM_CYC(ARM_CYC)) u_arm (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (arm),
        .open  (arm_open)
    );

    nvm_op_timer #(.ATOMIC_CYC(ATOMIC_CYC), .SPLIT_CYC(SPLIT_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .mode  (new_mode),
        .busy  (busy),
        .done  (done)
    );

    nvm_cell_array #(.ADDR_W(ADDR_W)) u_cells (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .mode    (new_mode),
        .addr    (ptr_q),
        .wdata   (data_q),
        .done    (done),
        .rd_addr (ptr_q),
        .rd_data (store_byte)
    );

    // Host-visible registers; the mode field survives a reset while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q     <= '0;
            data_q    <= '0;
            ie_q      <= 1'b0;
            rd_pend_q <= 1'b0;
            if (!busy) mode_q <= MODE_ATOMIC;
        end else begin
            rd_pend_q <= rd_req;
            if (wr_ptr) ptr_q <= host_wdata[ADDR_W-1:0];
            if (rd_pend_q) data_q <= store_byte;
            else if (wr_data) data_q <= host_wdata;
            if (wr_cmd) begin
                ie_q <= host_wdata[CMD_IE_BIT];
                if (!busy) mode_q <= new_mode;
            end
        end
    end

    // Read multiplexer for the selected register.
    always_comb begin
        case (host_sel)
            SEL_PTR:  host_rdata = 8'(ptr_q);
            SEL_DATA: host_rdata = data_q;
            SEL_CMD:  host_rdata = {2'b00, mode_q, ie_q, arm_open, busy, 1'b0};
            default:  host_rdata = '0;
        endcase
    end

    // Level interrupt while the store is ready.
    assign rdy_irq = ie_q && glob_ie && !busy;

    assert_start_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> arm_open);

    assert_mode_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mode_q));

    assert_read_blocked_R13: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !rd_pend_q);

    assert_irq_quiet_busy_R14: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rdy_irq);

endmodule

// File: tb/nvm_prog_ctrl_bench.sv
module nvm_prog_ctrl_bench;
    localparam int BCLK   = 10000;
    localparam int AT_CYC = BCLK * 34 / 10000;
    localparam int SP_CYC = BCLK * 18 / 10000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_sel = 2'd0;
    logic       host_we = 1'b0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic       glob_ie = 1'b0;
    logic       rdy_irq;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] model [128];
    logic [1:0] cur_mode = 2'b00;
    logic       cur_ie = 1'b0;

    always #10 clk = ~clk;

    nvm_prog_ctrl #(.ADDR_W(7), .CLK_HZ(BCLK), .ARM_CYC(4)) u_nvm_prog_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_sel   (host_sel),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .glob_ie    (glob_ie),
        .rdy_irq    (rdy_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] cw(logic [1:0] m, logic ie, logic arm, logic pe, logic re);
        return {2'b00, m, ie, arm, pe, re};
    endfunction

    // Write one register: call at a falling edge, returns at the next one.
    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        host_sel = sel; host_we = 1'b1; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] v);
        host_sel = sel;
        #1;
        v = host_rdata;
    endtask

    task automatic wait_idle(output int cyc);
        logic [7:0] c;
        cyc = 0;
        rd(2'd2, c);
        while (c[1] && cyc < 5000) begin
            cyc++;
            @(negedge clk);
            rd(2'd2, c);
        end
    endtask

    task automatic prog(input logic [6:0] a, input logic [7:0] d, input logic [1:0] m,
                        input string req);
        int cyc;
        wr(2'd0, {1'b0, a});
        wr(2'd1, d);
        wr(2'd2, cw(m, cur_ie, 1'b1, 1'b0, 1'b0));
        wr(2'd2, cw(m, cur_ie, 1'b0, 1'b1, 1'b0));
        cur_mode = m;
        if (cur_ie && glob_ie) chk("R14 irq low while busy", rdy_irq, 1'b0);
        wait_idle(cyc);
        chk({"R6 duration ", req}, cyc, (m == 2'b00) ? AT_CYC : SP_CYC);
        if (cur_ie && glob_ie) chk("R14 irq high when ready", rdy_irq, 1'b1);
        case (m)
            2'b00: model[a] = d;
            2'b01: model[a] = 8'hFF;
            2'b10: model[a] = model[a] & d;
            default: ;
        endcase
    endtask

    task automatic rdmem(input logic [6:0] a, output logic [7:0] v);
        wr(2'd0, {1'b0, a});
        wr(2'd2, cw(cur_mode, cur_ie, 1'b0, 1'b0, 1'b1));
        @(negedge clk);
        rd(2'd1, v);
    endtask

    task automatic do_reset();
        host_we = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int cyc;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        rd(2'd0, v); chk("R2 pointer reset", v, 8'h00);
        rd(2'd1, v); chk("R2 data reset", v, 8'h00);
        rd(2'd2, v); chk("R2 command reset", v, 8'h00);
        chk("R2 irq reset", rdy_irq, 1'b0);

        // R1 register access
        wr(2'd0, 8'hFF); rd(2'd0, v); chk("R1 pointer 7 bits", v, 8'h7F);
        wr(2'd1, 8'hA5); rd(2'd1, v); chk("R1 data readback", v, 8'hA5);
        wr(2'd3, 8'h5A); rd(2'd3, v); chk("R1 select 3 zero", v, 8'h00);

        // R3 layout and R4 arming window
        wr(2'd2, 8'hFC);
        rd(2'd2, v); chk("R3 command layout", v, 8'h3C);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); rd(2'd2, v); chk("R4 arm still open", v[2], 1'b1);
        end
        @(negedge clk); rd(2'd2, v); chk("R4 arm closed after 4", v[2], 1'b0);
        wr(2'd2, 8'h00);
        rd(2'd2, v); chk("R3 mode rewritten", v, 8'h00);

        // R14 interrupt gating
        cur_ie = 1'b1;
        wr(2'd2, cw(2'b00, 1'b1, 1'b0, 1'b0, 1'b0));
        chk("R14 irq gated by global", rdy_irq, 1'b0);
        glob_ie = 1'b1; #1;
        chk("R14 irq level when idle", rdy_irq, 1'b1);

        // R7 atomic sweep over every byte
        for (int a = 0; a < 128; a++) prog(7'(a), 8'((a * 37 + 11) ^ 8'h5C), 2'b00, "R7 atomic");
        for (int a = 0; a < 128; a++) begin
            rdmem(7'(a), v); chk("R7 R13 atomic readback", v, model[a]);
        end

        // R8 erase
        for (int a = 0; a < 16; a++) prog(7'(a), 8'h00, 2'b01, "R8 erase");
        for (int a = 0; a < 16; a++) begin
            rdmem(7'(a), v); chk("R8 erased byte", v, 8'hFF);
        end

        // R9 write-only onto erased and onto programmed bytes
        for (int a = 0; a < 32; a++) prog(7'(a), 8'(8'hC3 ^ (a * 29)), 2'b10, "R9 write-only");
        for (int a = 0; a < 32; a++) begin
            rdmem(7'(a), v); chk("R9 and-merged byte", v, model[a]);
        end

        // R10 reserved mode
        prog(7'd40, 8'h00, 2'b11, "R10 reserved");
        rdmem(7'd40, v); chk("R10 reserved unchanged", v, model[40]);

        // R5 window too late, same-write, and no arm
        wr(2'd0, 8'd50); wr(2'd1, 8'h11);
        wr(2'd2, cw(2'b00, 1'b1, 1'b1, 1'b0, 1'b0));
        repeat (4) @(negedge clk);
        wr(2'd2, cw(2'b00, 1'b1, 1'b0, 1'b1, 1'b0));
        rd(2'd2, v); chk("R5 late start ignored", v[1], 1'b0);
        wr(2'd2, cw(2'b00, 1'b1, 1'b1, 1'b1, 1'b0));
        rd(2'd2, v); chk("R5 same-write start ignored", v[1], 1'b0);
        repeat (5) @(negedge clk);
        wr(2'd2, cw(2'b00, 1'b1, 1'b0, 1'b1, 1'b0));
        rd(2'd2, v); chk("R5 unarmed start ignored", v[1], 1'b0);
        cur_mode = 2'b00;
        rdmem(7'd50, v); chk("R5 store unchanged", v, model[50]);

        // R5 last edge inside the window
        wr(2'd0, 8'd50); wr(2'd1, 8'h11);
        wr(2'd2, cw(2'b00, 1'b1, 1'b1, 1'b0, 1'b0));
        repeat (3) @(negedge clk);
        wr(2'd2, cw(2'b00, 1'b1, 1'b0, 1'b1, 1'b0));
        rd(2'd2, v); chk("R5 start on 4th edge", v[1], 1'b1);
        wait_idle(cyc);
        model[50] = 8'h11;
        rdmem(7'd50, v); chk("R5 window start stored", v, 8'h11);

        // R11 mode lock and R13 read ignored while busy
        wr(2'd0, 8'd60); wr(2'd1, 8'h3E);
        wr(2'd2, cw(2'b00, 1'b1, 1'b1, 1'b0, 1'b0));
        wr(2'd2, cw(2'b00, 1'b1, 1'b0, 1'b1, 1'b0));
        wr(2'd2, cw(2'b01, 1'b1, 1'b0, 1'b0, 1'b1));
        @(negedge clk);
        rd(2'd2, v); chk("R11 mode locked", v[5:4], 2'b00);
        chk("R11 still busy", v[1], 1'b1);
        rd(2'd1, v); chk("R13 read ignored while busy", v, 8'h3E);
        wr(2'd0, 8'd61); wr(2'd1, 8'h00);
        wait_idle(cyc);
        rd(2'd2, v); chk("R11 mode after op", v[5:4], 2'b00);
        model[60] = 8'h3E;
        rdmem(7'd60, v); chk("R11 captured target used", v, 8'h3E);
        rdmem(7'd61, v); chk("R11 other byte untouched", v, model[61]);

        // R12 reset during an erase
        wr(2'd0, 8'd70); wr(2'd1, 8'h00);
        wr(2'd2, cw(2'b01, 1'b1, 1'b1, 1'b0, 1'b0));
        wr(2'd2, cw(2'b01, 1'b1, 1'b0, 1'b1, 1'b0));
        repeat (3) @(negedge clk);
        do_reset();
        rd(2'd2, v); chk("R12 mode kept, busy on", v, 8'h12);
        rd(2'd0, v); chk("R12 pointer reset", v, 8'h00);
        wait_idle(cyc);
        cur_mode = 2'b01; cur_ie = 1'b0;
        model[70] = 8'hFF;
        rdmem(7'd70, v); chk("R12 erase completed", v, 8'hFF);
        do_reset();
        rd(2'd2, v); chk("R12 idle reset clears mode", v, 8'h00);
        chk("R2 irq after reset", rdy_irq, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule